// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This block sits between a single bus master and a word-addressed SRAM with a one-cycle synchronous read. Each request is a 32-bit word access. An address inside the alias window turns into a single-bit operation on a byte of the SRAM region. An alias read returns that bit in bit 0 of the response, with zeros in all other bits. An alias write runs an atomic read-modify-write of the SRAM word that holds the byte. Every other address passes through to the SRAM unchanged, using word address `req_addr[MEM_AW+1:2]`.

The request channel is valid/ready. The master raises `req_valid` and holds `req_write`, `req_addr` and `req_wdata` stable until a rising edge at which `req_ready` is high. That edge is the acceptance. `req_ready` falls only for the single cycle that follows an accepted alias write, while the SRAM write of the read-modify-write is issued. The response channel has no back-pressure. `rsp_valid` pulses for one cycle, the cycle after a read is accepted, and the master must take `rsp_rdata` in that cycle. Writes return no response.

Top module: `bitband_unit`

## Requirements
- R1: An address is an alias access when `req_addr[31:OFFSET_BITS+5]` equals the same bits of `ALIAS_BASE` (default 0x22000000, OFFSET_BITS 20). Its byte offset is `req_addr[OFFSET_BITS+4:5]` and its bit number is `req_addr[4:2]`, so 0x2202000C selects bit 3 of byte offset 0x1000. The SRAM word address is the byte offset shifted right by 2. Within that word the bit position is byte_offset[1:0]*8 + bit number (little-endian byte lanes).
- R2: An alias read gives `rsp_valid` high the cycle after acceptance. `rsp_rdata[0]` holds the selected bit and `rsp_rdata[31:1]` is zero.
- R3: An alias write takes only `req_wdata[0]` as the new bit value. All other data bits are ignored.
- R4: An alias write changes only the selected bit of the SRAM word. The other 31 bits keep their previous values, and the write goes to the same word that was read.
- R5: After an accepted alias write, `req_ready` is low for exactly one cycle. In that cycle the SRAM write is issued, so no other access can come between the read and the write.
- R6: A direct read is accepted without a stall. It returns the full SRAM word at `req_addr[MEM_AW+1:2]` with `rsp_valid` high the next cycle.
- R7: A direct write is accepted without a stall and writes `req_wdata` as a full word at `req_addr[MEM_AW+1:2]`.
- R8: Accepted writes, both alias and direct, never produce `rsp_valid`.
- R9: During and right after reset, `req_ready` is high, `rsp_valid` is low, and with no request pending `mem_en` is low.
- R10: Alias reads never lower `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | MEM_AW | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, valid the cycle after a read strobe |

## Verification
The bench builds the unit with the default 0x22000000 alias base and a 20-bit offset field, and sets MEM_AW to 11, which gives a 2048-word SRAM model. That depth covers byte offset 0x1000, so the bench can check the mapping example exactly and also exercise bits in byte lanes 0 and 2 of the same word. Direct accesses to 0x20001000 land on the same word, so alias and direct paths can be checked against each other.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 5;

  typedef enum logic {ST_IDLE, ST_MODIFY} rmw_state_e;

  typedef logic [SEL_W-1:0] bitsel_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter int unsigned OFFSET_BITS = 20,
  parameter int unsigned MEM_AW      = 12
) (
  input  logic [31:0]          addr,
  output logic                 hit,
  output logic [MEM_AW-1:0]    waddr,
  output bb_pkg::bitsel_t      sel
);
  localparam int unsigned WIN_LSB = OFFSET_BITS + 5;

  logic [OFFSET_BITS-1:0] byte_off;
  logic                   unused_bits;

  always_comb begin
    byte_off = addr[WIN_LSB-1:5];
    hit      = (addr[31:WIN_LSB] == ALIAS_BASE[31:WIN_LSB]);
    waddr    = hit ? byte_off[MEM_AW+1:2] : addr[MEM_AW+1:2];
    sel      = {byte_off[1:0], addr[4:2]};
  end

  assign unused_bits = ^{addr[1:0], byte_off};
endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq #(
  parameter int unsigned MEM_AW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [MEM_AW-1:0]         start_addr,
  input  bb_pkg::bitsel_t           start_sel,
  input  logic                      start_bit,
  input  logic [bb_pkg::WORD_W-1:0] rdata,
  output logic                      busy,
  output logic [MEM_AW-1:0]         wr_addr,
  output logic [bb_pkg::WORD_W-1:0] wr_data
);
  import bb_pkg::*;

  rmw_state_e          state_q;
  logic [MEM_AW-1:0]   addr_q;
  bitsel_t             sel_q;
  logic                bit_q;
  logic [WORD_W-1:0]   mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sel_q   <= '0;
      bit_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_MODIFY;
          addr_q  <= start_addr;
          sel_q   <= start_sel;
          bit_q   <= start_bit;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state_q == ST_MODIFY);
    mask    = {{(WORD_W-1){1'b0}}, 1'b1} << sel_q;
    wr_addr = addr_q;
    wr_data = bit_q ? (rdata | mask) : (rdata & ~mask);
  end

  AST_START_ENTERS_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R5
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R5
endmodule

// File: rtl/bb_resp.sv
module bb_resp (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_fire,
  input  logic                      rd_alias,
  input  bb_pkg::bitsel_t           rd_sel,
  input  logic [bb_pkg::WORD_W-1:0] mem_rdata,
  output logic                      rsp_valid,
  output logic [bb_pkg::WORD_W-1:0] rsp_rdata
);
  import bb_pkg::*;

  logic    alias_q;
  bitsel_t sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      alias_q   <= 1'b0;
      sel_q     <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        alias_q <= rd_alias;
        sel_q   <= rd_sel;
      end
    end
  end

  always_comb begin
    if (alias_q) rsp_rdata = {{(WORD_W-1){1'b0}}, mem_rdata[sel_q]};
    else         rsp_rdata = mem_rdata;
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rd_fire) |=> !rsp_valid); // R2
endmodule

// File: rtl/bitband_unit.sv
module bitband_unit #(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter int unsigned OFFSET_BITS = 20,
  parameter int unsigned MEM_AW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  import bb_pkg::*;

  logic              hit;
  logic [MEM_AW-1:0] dec_waddr;
  bitsel_t           dec_sel;
  logic              busy;
  logic [MEM_AW-1:0] rmw_addr;
  logic [WORD_W-1:0] rmw_data;
  logic              fire;
  logic              rmw_start;

  bb_decode #(.ALIAS_BASE(ALIAS_BASE), .OFFSET_BITS(OFFSET_BITS), .MEM_AW(MEM_AW)) u_dec (
    .addr(req_addr), .hit(hit), .waddr(dec_waddr), .sel(dec_sel)
  );

  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;
  assign rmw_start = fire && req_write && hit;

  bb_rmw_seq #(.MEM_AW(MEM_AW)) u_rmw (
    .clk(clk), .rst_n(rst_n), .start(rmw_start), .start_addr(dec_waddr),
    .start_sel(dec_sel), .start_bit(req_wdata[0]), .rdata(mem_rdata),
    .busy(busy), .wr_addr(rmw_addr), .wr_data(rmw_data)
  );

  bb_resp u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_fire(fire && !req_write), .rd_alias(hit),
    .rd_sel(dec_sel), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always_comb begin
    mem_en    = fire || busy;
    mem_we    = busy || (fire && req_write && !hit);
    mem_addr  = busy ? rmw_addr : dec_waddr;
    mem_wdata = busy ? rmw_data : req_wdata;
  end

  AST_READ_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fire && !req_write) |-> rsp_valid); // R2
  AST_ALIAS_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fire && !req_write && hit) |-> (rsp_rdata[31:1] == '0)); // R2
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fire && req_write) |-> !rsp_valid); // R8
  AST_RMW_LOCKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && rmw_start) |-> (!req_ready && mem_en && mem_we)); // R5
  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && rmw_start) |-> (mem_addr == $past(mem_addr))); // R4
  AST_STALL_ONLY_AFTER_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(rst_n)) |-> $past(rmw_start)); // R10
endmodule

// File: tb/bitband_unit_tb.sv
module bitband_unit_tb;
  localparam int unsigned AW = 11;
  localparam logic [31:0] ABASE = 32'h2200_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [31:0] sram [0:(1<<AW)-1];
  int checks = 0, errors = 0;
  bit stall_seen;

  always #10 clk = ~clk;

  bitband_unit #(.ALIAS_BASE(ABASE), .OFFSET_BITS(20), .MEM_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      mem_rdata <= sram[mem_addr];
    end
  end

  function automatic logic [31:0] alias_of(input logic [19:0] off, input int b);
    return ABASE + {7'd0, off, 5'd0} + 32'(b * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drives one request; returns the response if read; notes stalls after acceptance
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic rv, output logic rdy_after,
                        output logic we_after);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; stall_seen = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    rd = rsp_rdata; rv = rsp_valid; rdy_after = req_ready; we_after = mem_we;
  endtask

  task automatic t_reset;
    check("R9 ready", {31'd0, req_ready}, 32'd1);
    check("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R9 mem_en", {31'd0, mem_en}, 32'd0);
  endtask

  task automatic t_direct;
    logic [31:0] rd; logic rv, ry, we;
    stall_seen = 1'b0;
    access(1'b1, 32'h2000_1000, 32'hA5C3_0F08, rd, rv, ry, we);
    check("R8 direct write no rsp", {31'd0, rv}, 32'd0);
    check("R7 direct write no stall", {31'd0, ry}, 32'd1);
    check("R7 sram word", sram[11'h400], 32'hA5C3_0F08);
    access(1'b0, 32'h2000_1000, 32'h0, rd, rv, ry, we);
    check("R6 rsp_valid", {31'd0, rv}, 32'd1);
    check("R6 full word", rd, 32'hA5C3_0F08);
    check("R6 R7 no stall", {31'd0, stall_seen}, 32'd0);
  endtask

  task automatic t_alias_read;
    logic [31:0] rd; logic rv, ry, we;
    stall_seen = 1'b0;
    check("R1 mapping example", alias_of(20'h01000, 3), 32'h2202_000C);
    access(1'b0, 32'h2202_000C, 32'h0, rd, rv, ry, we);
    check("R2 alias bit3 valid", {31'd0, rv}, 32'd1);
    check("R1 R2 alias bit3", rd, 32'd1);
    access(1'b0, alias_of(20'h01000, 4), 32'h0, rd, rv, ry, we);
    check("R2 alias bit4 zero", rd, 32'd0);
    access(1'b0, alias_of(20'h01002, 7), 32'h0, rd, rv, ry, we);
    check("R1 byte lane 2 bit7", rd, 32'd1);
    access(1'b0, alias_of(20'h01003, 0), 32'h0, rd, rv, ry, we);
    check("R1 byte lane 3 bit0", rd, 32'd1);
    check("R10 alias read no stall", {31'd0, stall_seen}, 32'd0);
  endtask

  task automatic t_alias_write;
    logic [31:0] rd; logic rv, ry, we;
    access(1'b1, alias_of(20'h01000, 3), 32'hFFFF_FFFE, rd, rv, ry, we);
    check("R5 ready low after alias write", {31'd0, ry}, 32'd0);
    check("R5 sram write issued", {31'd0, we}, 32'd1);
    check("R8 alias write no rsp", {31'd0, rv}, 32'd0);
    @(negedge clk); #1;
    check("R5 ready back", {31'd0, req_ready}, 32'd1);
    check("R3 R4 clear bit3 only", sram[11'h400], 32'hA5C3_0F00);
    access(1'b1, alias_of(20'h01001, 4), 32'h0000_0001, rd, rv, ry, we);
    @(negedge clk);
    check("R4 set bit12 only", sram[11'h400], 32'hA5C3_1F00);
    access(1'b1, alias_of(20'h01003, 7), 32'h7FFF_FFFE, rd, rv, ry, we);
    @(negedge clk);
    check("R3 upper data ignored", sram[11'h400], 32'h25C3_1F00);
  endtask

  task automatic t_back_to_back;
    logic [31:0] rd; logic rv, ry, we;
    access(1'b1, alias_of(20'h01002, 0), 32'h1, rd, rv, ry, we);
    access(1'b0, alias_of(20'h01002, 0), 32'h0, rd, rv, ry, we);
    check("R5 read after rmw sees new bit", rd, 32'd1);
    access(1'b0, 32'h2000_1000, 32'h0, rd, rv, ry, we);
    check("R4 direct view after rmw", rd, 32'h25C3_1F00 | 32'h0001_0000);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) sram[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_direct();
    t_alias_read();
    t_alias_write();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule